// File: doc/BRIEF.md
# UART Text Command to MDIO Management Bridge

This block lets a person at a serial terminal read and write PHY management registers. It receives ASCII lines over an 8N1 UART and parses them into clause-22 MDIO frames. It sends each result back as uppercase hexadecimal text. Three commands exist: `miim0 y` / `miim0 n` opens or closes the management port; `rd PPRR NN` reads register RR of PHY PP NN times in a row; `wr PPRR DDDD` writes DDDD to register RR of PHY PP. All numeric fields are hexadecimal.

A write is answered with its own data field, not with a read-back. A read is answered with the value or values the PHY returned. Both keyword replies end in CR LF. Characters are collected only while the engine is waiting for a line. Anything typed while a command is executing or its reply is being sent is dropped.

The command engine is a single state machine with these states. `E_COLLECT` gathers characters. `E_DECODE` classifies the line. `E_FRAME_GO` and `E_FRAME_WAIT` launch and await one MDIO frame. `E_SEND_HEX`, `E_SEND_SEP` and `E_SEND_MSG` emit hex digits, a space separator, or the keyword `OK`/`ERR`. `E_SEND_CR` and `E_SEND_LF` emit the line end.

The transitions are as follows:
- COLLECT to DECODE on CR or LF after a non-empty line.
- DECODE to SEND_MSG for a port command, a malformed line, or a register command on a closed port.
- DECODE to FRAME_GO for a valid register command on an open port.
- FRAME_GO to FRAME_WAIT always.
- FRAME_WAIT to SEND_HEX on frame completion.
- SEND_HEX, after its fourth digit, to SEND_SEP if reads remain, otherwise to SEND_CR.
- SEND_SEP to FRAME_GO.
- SEND_MSG to SEND_CR after the last letter.
- SEND_CR to SEND_LF.
- SEND_LF to COLLECT.

Top module: `uart_mdio_bridge`

## Requirements
- R1: The UART uses 8N1 framing, LSB first, with CLK_HZ/BAUD clocks per bit; `uart_txd` idles high from reset and a new byte starts only when the transmitter is idle.
- R2: `miim0 y` opens the management port and `miim0 n` closes it; each is answered `OK` CR LF; the port is closed after reset.
- R3: A register command issued while the port is closed is answered `ERR` CR LF and produces no MDIO frame.
- R4: `rd PPRR NN` (NN from 01 to FF) performs NN read frames to the same register; each result is 4 uppercase hex digits, results are separated by one space, and the line ends CR LF.
- R5: `wr PPRR DDDD` performs one write frame carrying DDDD and is answered with DDDD in uppercase.
- R6: Each frame is 32 ones, start 01, opcode 10 (read) or 01 (write), 5-bit PHY, 5-bit register, turnaround, then 16 data bits MSB first. The turnaround is driven 10 on writes and released on reads. `mdio_o` changes only while MDC is low, read data is sampled on the MDC rising edge, and `mdio_oe` is high only during a frame.
- R7: MDC has a period of 2*MDC_HALF clocks, where MDC_HALF = ceil(CLK_HZ/(2*MDC_HZ)); MDC stays low between frames.
- R8: Hex digits are accepted in upper or lower case.
- R9: A malformed line is answered `ERR` CR LF with no frame. Malformed means any of: wrong length, unknown keyword, missing space, non-hex digit, PHY or register above 1F, read count 00, or more than 12 characters.
- R10: A line ends on CR or on LF; an empty line produces no reply.
- R11: Characters received while a command executes or a reply is being sent are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_rxd | input | 1 | Serial command input, idle high |
| uart_txd | output | 1 | Serial reply output, idle high |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the PHY |
| mdio_o | output | 1 | Management data to the PHY |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |

## Verification
Two functions can fall in the same cycle: the receiver completing a byte, and the engine being busy sending a reply. The bench provokes this by sending a stray character while the reply to a repeated read is still being sent. The result is judged at the ports. The reply must be unchanged, and the next command must be answered as if the stray byte had never arrived; had the byte been collected, that command would return `ERR`. A behavioural PHY model logs every frame, so a dropped or extra frame is caught.

// File: rtl/umb_pkg.sv
package umb_pkg;

    localparam int LINE_MAX = 12;

    typedef enum logic [3:0] {
        E_COLLECT,
        E_DECODE,
        E_FRAME_GO,
        E_FRAME_WAIT,
        E_SEND_HEX,
        E_SEND_SEP,
        E_SEND_MSG,
        E_SEND_CR,
        E_SEND_LF
    } eng_state_t;

    typedef enum logic [1:0] {
        K_BAD,
        K_PORT,
        K_READ,
        K_WRITE
    } cmd_kind_t;

    // {valid, nibble}
    function automatic logic [4:0] hex_val(input logic [7:0] c);
        if (c >= 8'h30 && c <= 8'h39)
            return {1'b1, c[3:0]};
        else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
            return {1'b1, c[3:0] + 4'd9};
        else
            return 5'd0;
    endfunction

    function automatic logic [7:0] hex_chr(input logic [3:0] n);
        if (n < 4'd10)
            return 8'h30 + {4'd0, n};
        else
            return 8'h37 + {4'd0, n};
    endfunction

endpackage

// File: rtl/umb_uart_rx.sv
module umb_uart_rx #(
    parameter int CLKS_PER_BIT = 13021
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] BIT_LAST  = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    rx_state_t       st;
    logic [1:0]      sync;
    logic [CW-1:0]   cnt;
    logic [2:0]      idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            sync  <= 2'b11;
            cnt   <= '0;
            idx   <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            sync  <= {sync[0], rxd};
            valid <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!sync[1]) st <= RX_START;
                end
                RX_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt <= '0;
                        idx <= '0;
                        st  <= sync[1] ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == BIT_LAST) begin
                        cnt  <= '0;
                        data <= {sync[1], data[7:1]};
                        if (idx == 3'd7) st <= RX_STOP;
                        else             idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == BIT_LAST) begin
                        st    <= RX_IDLE;
                        valid <= sync[1];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/umb_uart_tx.sv
module umb_uart_tx #(
    parameter int CLKS_PER_BIT = 13021
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] byte_in,
    output logic       txd,
    output logic       busy
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(CLKS_PER_BIT - 1);

    logic [9:0]    sh;
    logic [3:0]    n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd  <= 1'b1;
            busy <= 1'b0;
            sh   <= '1;
            n    <= '0;
            cnt  <= '0;
        end else if (!busy) begin
            if (go) begin
                busy <= 1'b1;
                sh   <= {1'b1, byte_in, 1'b0};
                txd  <= 1'b0;
                n    <= '0;
                cnt  <= '0;
            end
        end else if (cnt == BIT_LAST) begin
            cnt <= '0;
            if (n == 4'd9) begin
                busy <= 1'b0;
            end else begin
                n   <= n + 1'b1;
                sh  <= {1'b1, sh[9:1]};
                txd <= sh[1];
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/umb_mdio_master.sv
module umb_mdio_master #(
    parameter int MDC_HALF = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr,
    input  logic [4:0]  phy,
    input  logic [4:0]  reg_a,
    input  logic [15:0] wdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata
);
    localparam int FRAME_BITS = 64;
    localparam int DATA_FIRST = 48;
    localparam int TA_FIRST   = 46;
    localparam int BW = $clog2(FRAME_BITS);
    localparam int DW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(MDC_HALF - 1);

    logic [FRAME_BITS-1:0] sh;
    logic [BW-1:0]         bitn;
    logic                  is_wr;
    logic [DW-1:0]         div;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            bitn    <= '0;
            is_wr   <= 1'b0;
            div     <= '0;
            mdc     <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                div <= '0;
                if (start) begin
                    busy    <= 1'b1;
                    is_wr   <= wr;
                    sh      <= {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10),
                                phy, reg_a, 2'b10, (wr ? wdata : 16'h0000)};
                    bitn    <= '0;
                    mdc     <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end
            end else if (div == DIV_LAST) begin
                div <= '0;
                if (!mdc) begin
                    mdc <= 1'b1;
                    if (!is_wr && int'(bitn) >= DATA_FIRST)
                        rdata <= {rdata[14:0], mdio_i};
                end else begin
                    mdc <= 1'b0;
                    if (int'(bitn) == FRAME_BITS - 1) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b1;
                    end else begin
                        bitn    <= bitn + 1'b1;
                        sh      <= {sh[FRAME_BITS-2:0], 1'b0};
                        mdio_o  <= sh[FRAME_BITS-2];
                        mdio_oe <= is_wr || (int'(bitn) < TA_FIRST - 1);
                    end
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end
endmodule

// File: rtl/umb_cmd_engine.sv
module umb_cmd_engine
    import umb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_busy,
    output logic        tx_go,
    output logic [7:0]  tx_byte,
    output logic        frame_start,
    output logic        frame_wr,
    output logic [4:0]  frame_phy,
    output logic [4:0]  frame_reg,
    output logic [15:0] frame_wdata,
    input  logic        frame_done,
    input  logic [15:0] frame_rdata,
    output logic        port_en
);
    localparam int LW = $clog2(LINE_MAX + 2);

    eng_state_t  st, st_nx;
    logic [7:0]  line_q [LINE_MAX];
    logic [LW-1:0] len_q;
    logic [7:0]  cnt_left;
    logic [15:0] word_q;
    logic [1:0]  nib_q;
    logic [1:0]  msg_idx;
    logic        msg_err;

    logic        rx_eol, tx_ok, msg_last, a_ok;
    logic [4:0]  h3, h4, h5, h6, h8, h9, h10, h11;
    logic [4:0]  d_phy, d_reg;
    logic [7:0]  d_cnt;
    logic [15:0] d_data;
    logic [7:0]  msg_chr;
    cmd_kind_t   kind;

    assign rx_eol   = (rx_byte == 8'h0D) || (rx_byte == 8'h0A);
    assign tx_ok    = !tx_busy && !tx_go;
    assign msg_last = msg_err ? (msg_idx == 2'd2) : (msg_idx == 2'd1);

    // line classification from fixed field positions
    always_comb begin
        h3  = hex_val(line_q[3]);
        h4  = hex_val(line_q[4]);
        h5  = hex_val(line_q[5]);
        h6  = hex_val(line_q[6]);
        h8  = hex_val(line_q[8]);
        h9  = hex_val(line_q[9]);
        h10 = hex_val(line_q[10]);
        h11 = hex_val(line_q[11]);
        a_ok   = h3[4] && h4[4] && h5[4] && h6[4] &&
                 (h3[3:1] == 3'd0) && (h5[3:1] == 3'd0) && (line_q[7] == " ");
        d_phy  = {h3[0], h4[3:0]};
        d_reg  = {h5[0], h6[3:0]};
        d_cnt  = {h8[3:0], h9[3:0]};
        d_data = {h8[3:0], h9[3:0], h10[3:0], h11[3:0]};
        kind   = K_BAD;
        if (int'(len_q) == 7 && line_q[0] == "m" && line_q[1] == "i" &&
            line_q[2] == "i" && line_q[3] == "m" && line_q[4] == "0" &&
            line_q[5] == " " && (line_q[6] == "y" || line_q[6] == "n"))
            kind = K_PORT;
        else if (int'(len_q) == 10 && line_q[0] == "r" && line_q[1] == "d" &&
                 line_q[2] == " " && a_ok && h8[4] && h9[4] && d_cnt != 8'd0)
            kind = K_READ;
        else if (int'(len_q) == 12 && line_q[0] == "w" && line_q[1] == "r" &&
                 line_q[2] == " " && a_ok && h8[4] && h9[4] && h10[4] && h11[4])
            kind = K_WRITE;
    end

    always_comb begin
        unique case ({msg_err, msg_idx})
            3'b000:  msg_chr = "O";
            3'b001:  msg_chr = "K";
            3'b100:  msg_chr = "E";
            default: msg_chr = "R";
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= E_COLLECT;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            E_COLLECT:    if (rx_valid && rx_eol && len_q != '0) st_nx = E_DECODE;
            E_DECODE: begin
                if ((kind == K_READ || kind == K_WRITE) && port_en) st_nx = E_FRAME_GO;
                else                                                  st_nx = E_SEND_MSG;
            end
            E_FRAME_GO:   st_nx = E_FRAME_WAIT;
            E_FRAME_WAIT: if (frame_done) st_nx = E_SEND_HEX;
            E_SEND_HEX:   if (tx_ok && nib_q == 2'd3)
                              st_nx = (cnt_left != 8'd0) ? E_SEND_SEP : E_SEND_CR;
            E_SEND_SEP:   if (tx_ok) st_nx = E_FRAME_GO;
            E_SEND_MSG:   if (tx_ok && msg_last) st_nx = E_SEND_CR;
            E_SEND_CR:    if (tx_ok) st_nx = E_SEND_LF;
            E_SEND_LF:    if (tx_ok) st_nx = E_COLLECT;
            default:      st_nx = E_COLLECT;
        endcase
    end

    assign frame_start = (st == E_FRAME_GO);

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINE_MAX; i++) line_q[i] <= 8'h00;
            len_q       <= '0;
            cnt_left    <= '0;
            word_q      <= '0;
            nib_q       <= '0;
            msg_idx     <= '0;
            msg_err     <= 1'b0;
            port_en     <= 1'b0;
            tx_go       <= 1'b0;
            tx_byte     <= 8'h00;
            frame_wr    <= 1'b0;
            frame_phy   <= '0;
            frame_reg   <= '0;
            frame_wdata <= '0;
        end else begin
            tx_go <= 1'b0;
            unique case (st)
                E_COLLECT: begin
                    if (rx_valid && !rx_eol) begin
                        if (int'(len_q) < LINE_MAX) begin
                            line_q[len_q] <= rx_byte;
                            len_q         <= len_q + 1'b1;
                        end else begin
                            len_q <= LW'(LINE_MAX + 1);
                        end
                    end
                end
                E_DECODE: begin
                    len_q       <= '0;
                    msg_idx     <= '0;
                    msg_err     <= (kind != K_PORT);
                    frame_wr    <= (kind == K_WRITE);
                    frame_phy   <= d_phy;
                    frame_reg   <= d_reg;
                    frame_wdata <= d_data;
                    cnt_left    <= (kind == K_WRITE) ? 8'd1 : d_cnt;
                    if (kind == K_PORT) port_en <= (line_q[6] == "y");
                end
                E_FRAME_WAIT: begin
                    if (frame_done) begin
                        word_q   <= frame_wr ? frame_wdata : frame_rdata;
                        nib_q    <= '0;
                        cnt_left <= cnt_left - 8'd1;
                    end
                end
                E_SEND_HEX: begin
                    if (tx_ok) begin
                        tx_go   <= 1'b1;
                        tx_byte <= hex_chr(word_q[15:12]);
                        word_q  <= {word_q[11:0], 4'h0};
                        nib_q   <= nib_q + 1'b1;
                    end
                end
                E_SEND_SEP: if (tx_ok) begin tx_go <= 1'b1; tx_byte <= 8'h20; end
                E_SEND_MSG: begin
                    if (tx_ok) begin
                        tx_go   <= 1'b1;
                        tx_byte <= msg_chr;
                        msg_idx <= msg_idx + 1'b1;
                    end
                end
                E_SEND_CR: if (tx_ok) begin tx_go <= 1'b1; tx_byte <= 8'h0D; end
                E_SEND_LF: if (tx_ok) begin tx_go <= 1'b1; tx_byte <= 8'h0A; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_mdio_bridge.sv
module uart_mdio_bridge #(
    parameter int CLK_HZ = 125_000_000,
    parameter int BAUD   = 9600,
    parameter int MDC_HZ = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uart_rxd,
    output logic uart_txd,
    output logic mdc,
    input  logic mdio_i,
    output logic mdio_o,
    output logic mdio_oe
);
    localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
    localparam int MDC_HALF     = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);

    logic        rx_valid, tx_go, tx_busy, port_en;
    logic [7:0]  rx_byte, tx_byte;
    logic        frame_start, frame_wr, frame_done, mdio_busy;
    logic [4:0]  frame_phy, frame_reg;
    logic [15:0] frame_wdata, frame_rdata;

    umb_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(uart_rxd), .valid(rx_valid), .data(rx_byte));

    umb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .go(tx_go), .byte_in(tx_byte),
        .txd(uart_txd), .busy(tx_busy));

    umb_cmd_engine u_eng (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_busy(tx_busy), .tx_go(tx_go), .tx_byte(tx_byte),
        .frame_start(frame_start), .frame_wr(frame_wr), .frame_phy(frame_phy),
        .frame_reg(frame_reg), .frame_wdata(frame_wdata), .frame_done(frame_done),
        .frame_rdata(frame_rdata), .port_en(port_en));

    umb_mdio_master #(.MDC_HALF(MDC_HALF)) u_mdio (
        .clk(clk), .rst_n(rst_n), .start(frame_start), .wr(frame_wr),
        .phy(frame_phy), .reg_a(frame_reg), .wdata(frame_wdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(mdio_busy),
        .done(frame_done), .rdata(frame_rdata));
endmodule

// File: rtl/uart_mdio_bridge_chk.sv
module uart_mdio_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic mdio_busy,
    input logic frame_start,
    input logic port_en,
    input logic tx_go,
    input logic tx_busy
);
    // R1
    tx_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> !tx_busy);

    // R7
    mdc_rest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_busy |-> !mdc);

    // R6
    mdio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o));

    // R6
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> mdio_busy);

    // R3
    frame_port_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> port_en);
endmodule

bind uart_mdio_bridge uart_mdio_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_busy(mdio_busy), .frame_start(frame_start), .port_en(port_en),
    .tx_go(tx_go), .tx_busy(tx_busy));

// File: tb/tb_uart_mdio_bridge.sv
`timescale 1ns/1ps
module tb_uart_mdio_bridge;
    localparam int CLK_HZ = 125_000_000;
    localparam int BAUD   = 15_625_000;
    localparam int MDC_HZ = 31_250_000;
    localparam int CPB    = CLK_HZ / BAUD;                          // 8
    localparam int MH     = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ); // 2

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uart_rxd = 1'b1;
    logic mdio_i = 1'b1;
    logic uart_txd, mdc, mdio_o, mdio_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uart_mdio_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .MDC_HZ(MDC_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .uart_rxd(uart_rxd), .uart_txd(uart_txd),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

    // ---------------- behavioural PHY model ----------------
    logic [15:0] regmem [int];
    logic [15:0] counter_reg = 16'h0010;
    logic [27:0] frame_log [$];
    int          k = 0;
    logic [63:0] cap;
    logic [15:0] rd_val;
    logic        is_rd = 1'b0;
    int          bad_frame = 0;
    int          bad_mdc = 0;
    realtime     last_rise = 0;

    function automatic logic [15:0] model_read(input logic [4:0] p, input logic [4:0] r);
        int key = int'(p) * 32 + int'(r);
        if (r == 5'h1E) begin
            model_read = counter_reg;
            counter_reg = counter_reg + 16'd1;
        end else if (regmem.exists(key)) begin
            model_read = regmem[key];
        end else begin
            model_read = {p, r, 6'h2A};
        end
    endfunction

    always @(posedge mdc) begin
        if (k > 0 && (($realtime - last_rise) != real'(2 * MH * 8))) bad_mdc++;
        last_rise = $realtime;
        if (k == 46) begin
            if (cap[63:32] != 32'hFFFF_FFFF || cap[31:30] != 2'b01) bad_frame++;
            if (cap[29:28] == 2'b10) begin
                is_rd  = 1'b1;
                rd_val = model_read(cap[27:23], cap[22:18]);
            end else if (cap[29:28] == 2'b01) begin
                is_rd = 1'b0;
            end else begin
                bad_frame++;
            end
        end
        if (k < 46 || !is_rd) begin
            if (!mdio_oe) bad_frame++;
            cap[63-k] = mdio_o;
        end else if (mdio_oe) begin
            bad_frame++;
        end
        if (k == 47 && !is_rd && cap[17:16] != 2'b10) bad_frame++;
        if (k == 63) begin
            if (is_rd) begin
                frame_log.push_back({cap[29:18], rd_val});
            end else begin
                frame_log.push_back(cap[29:0] >> 2 << 2 >> 2 == 0 ? 28'd0 : {cap[29:18], cap[15:0]});
                regmem[int'(cap[27:23]) * 32 + int'(cap[22:18])] = cap[15:0];
            end
            k = 0;
        end else begin
            k++;
        end
    end

    always @(negedge mdc) begin
        if (is_rd && k >= 48 && k <= 63) mdio_i = rd_val[63-k];
        else                             mdio_i = 1'b1;
    end

    // ---------------- UART reply receiver ----------------
    byte rxq [$];
    initial begin
        logic [7:0] ch;
        forever begin
            @(negedge clk);
            if (rst_n && uart_txd == 1'b0) begin
                repeat (CPB / 2) @(negedge clk);
                for (int b = 0; b < 8; b++) begin
                    repeat (CPB) @(negedge clk);
                    ch[b] = uart_txd;
                end
                repeat (CPB) @(negedge clk);
                rxq.push_back(ch);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        uart_rxd = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            uart_rxd = c[b];
            repeat (CPB) @(negedge clk);
        end
        uart_rxd = 1'b1;
        repeat (2 * CPB) @(negedge clk);
    endtask

    task automatic send_text(input string s, input logic [7:0] eol);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
        send_char(eol);
    endtask

    function automatic string vis(input logic [7:0] c);
        if (c == 8'h0D) return "\\r";
        if (c == 8'h0A) return "\\n";
        return $sformatf("%c", c);
    endfunction

    task automatic expect_line(input string req, input string exp);
        string got = "";
        string want;
        int    n = exp.len() + 2;
        int    waitc = 0;
        want = {exp, "\\r\\n"};
        while (rxq.size() < n && waitc < 40000) begin
            @(negedge clk);
            waitc++;
        end
        for (int i = 0; i < n && rxq.size() > 0; i++) got = {got, vis(rxq.pop_front())};
        n_tests++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s reply: actual \"%s\" expected \"%s\"", req, got, want);
        end
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        repeat (cycles) @(negedge clk);
        n_tests++;
        if (rxq.size() != 0) begin
            n_fail++;
            $display("FAIL %s quiet: actual %0d chars expected 0", req, rxq.size());
            rxq.delete();
        end
    endtask

    task automatic expect_frame(input string req, input logic [27:0] exp);
        logic [27:0] got;
        n_tests++;
        if (frame_log.size() == 0) begin
            n_fail++;
            $display("FAIL %s frame: actual none expected %h", req, exp);
        end else begin
            got = frame_log.pop_front();
            if (got != exp) begin
                n_fail++;
                $display("FAIL %s frame: actual %h expected %h", req, got, exp);
            end
        end
    endtask

    task automatic expect_no_frame(input string req);
        n_tests++;
        if (frame_log.size() != 0) begin
            n_fail++;
            $display("FAIL %s frames: actual %0d expected 0", req, frame_log.size());
            frame_log.delete();
        end
    endtask

    function automatic logic [27:0] fr(input logic [1:0] op, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
        return {op, p, r, d};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R7: reset state
        n_tests++;
        if (uart_txd !== 1'b1 || mdc !== 1'b0 || mdio_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual txd=%b mdc=%b oe=%b expected 1 0 0",
                     uart_txd, mdc, mdio_oe);
        end

        // R3: port closed after reset
        send_text("rd 0102 01", 8'h0D);
        expect_line("R3", "ERR");
        expect_no_frame("R3");

        // R2: open port
        send_text("miim0 y", 8'h0D);
        expect_line("R2", "OK");

        // R5 R6: write echoes data
        send_text("wr 0105 BEEF", 8'h0D);
        expect_line("R5", "BEEF");
        expect_frame("R5 R6", fr(2'b01, 5'h01, 5'h05, 16'hBEEF));

        // R4 R6: single read returns stored value
        send_text("rd 0105 01", 8'h0D);
        expect_line("R4", "BEEF");
        expect_frame("R4 R6", fr(2'b10, 5'h01, 5'h05, 16'hBEEF));

        // R8: lower-case hex, uppercase echo
        send_text("wr 1f1a abcd", 8'h0D);
        expect_line("R8", "ABCD");
        expect_frame("R8", fr(2'b01, 5'h1F, 5'h1A, 16'hABCD));

        // R4: repeated read of a counting register
        send_text("rd 021E 03", 8'h0D);
        expect_line("R4 repeat", "0010 0011 0012");
        expect_frame("R4 repeat", fr(2'b10, 5'h02, 5'h1E, 16'h0010));
        expect_frame("R4 repeat", fr(2'b10, 5'h02, 5'h1E, 16'h0011));
        expect_frame("R4 repeat", fr(2'b10, 5'h02, 5'h1E, 16'h0012));

        // R9: malformed lines
        send_text("rd 0102", 8'h0D);
        expect_line("R9 short", "ERR");
        send_text("xx 0102 01", 8'h0D);
        expect_line("R9 keyword", "ERR");
        send_text("rd 0102 00", 8'h0D);
        expect_line("R9 count zero", "ERR");
        send_text("rd 2002 01", 8'h0D);
        expect_line("R9 phy range", "ERR");
        send_text("wr 01G2 0000", 8'h0D);
        expect_line("R9 non-hex", "ERR");
        send_text("wr 0105 BEEF00", 8'h0D);
        expect_line("R9 overlong", "ERR");
        expect_no_frame("R9");

        // R10: empty line silent, LF terminates
        send_char(8'h0D);
        expect_quiet("R10 empty", 300);
        send_text("rd 0105 01", 8'h0A);
        expect_line("R10 LF", "BEEF");
        expect_frame("R10", fr(2'b10, 5'h01, 5'h05, 16'hBEEF));

        // R2 R3: closed port blocks writes
        send_text("miim0 n", 8'h0D);
        expect_line("R2 close", "OK");
        send_text("wr 0105 0000", 8'h0D);
        expect_line("R3 closed", "ERR");
        expect_no_frame("R3 closed");
        send_text("miim0 y", 8'h0D);
        expect_line("R2 reopen", "OK");
        send_text("rd 0105 01", 8'h0D);
        expect_line("R3 unchanged", "BEEF");
        expect_frame("R3", fr(2'b10, 5'h01, 5'h05, 16'hBEEF));

        // R11: stray byte during reply is dropped
        send_text("rd 021E 02", 8'h0D);
        while (rxq.size() < 1) @(negedge clk);
        send_char("x");
        expect_line("R11 reply", "0013 0014");
        expect_frame("R11", fr(2'b10, 5'h02, 5'h1E, 16'h0013));
        expect_frame("R11", fr(2'b10, 5'h02, 5'h1E, 16'h0014));
        send_text("rd 0105 01", 8'h0D);
        expect_line("R11 next", "BEEF");
        expect_frame("R11 next", fr(2'b10, 5'h01, 5'h05, 16'hBEEF));

        // R6 R7: frame shape and MDC period over the whole run
        n_tests++;
        if (bad_frame != 0) begin
            n_fail++;
            $display("FAIL R6 frame shape: actual %0d errors expected 0", bad_frame);
        end
        n_tests++;
        if (bad_mdc != 0) begin
            n_fail++;
            $display("FAIL R7 mdc period: actual %0d errors expected 0", bad_mdc);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule